// File: doc/BRIEF.md
# CAN transmit mailbox priority selector

This block decides which message center of one CAN controller has its frame placed in the controller's transmit buffer. Each center has three qualifying conditions: a pending transmit request (raised by a one-cycle request pulse and held inside the block), a ready bit and a transmit-direction bit. The eligible center with the smallest number is the one loaded. The highest-numbered center is receive-only and is never chosen.

The protocol engine reports three events: the frame was sent, arbitration was lost, or an error occurred. On a successful send, the loaded center's pending request is dropped and a completion pulse carries its number. On lost arbitration or an error, the block does not simply retry the same frame. It picks again from the centers that are eligible at that moment and reloads the buffer with the winner. A higher-priority frame that became ready in the meantime therefore displaces the old one, so no priority inversion occurs. When no frame is loaded, the block waits for the bus to be idle and picks then, so the choice reflects the latest state of the centers.

Top module: `mbsel_tx_select`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `load_stb` and `done_pulse` are 0 and `sel_ctr` is 0. Reset also clears every pending request, so no center can be loaded until a new request pulse arrives.
- R2: Bit i of `tx_req_set`, `ctr_ready` and `ctr_tx_dir` belongs to center i+1. A center is eligible only when its pending request is set, its ready bit is 1 and its direction bit is 1. A pulse on `tx_req_set` sets the request from the next cycle on. The request stays set until that center's frame is sent.
- R3: Center numbers on `sel_ctr` and `done_ctr` run from 1 to N_CTR, and 0 means none. On every load, `sel_ctr` is the lowest-numbered center that was eligible in the cycle before the strobe.
- R4: Center N_CTR is never placed on `sel_ctr`, whatever its inputs.
- R5: While no frame is loaded, a load happens only in a cycle that has `bus_idle` high and at least one eligible center. `load_stb` is high for one cycle in the following cycle. The pick uses the eligibility present in that idle cycle, so a center readied earlier while the bus was busy takes the place of a lower-priority one.
- R6: While a frame is loaded, `ev_arb_lost` causes a reload in the next cycle of the lowest-numbered eligible center. This may be the same center again.
- R7: While a frame is loaded, `ev_error` causes the same reload as R6.
- R8: While a frame is loaded, `ev_tx_ok` produces `done_pulse` for one cycle in the next cycle. In that cycle `done_ctr` equals the sent center, `sel_ctr` is 0 and `load_stb` is 0. That center's pending request is cleared. `ev_tx_ok` takes precedence over an `ev_arb_lost` or `ev_error` in the same cycle.
- R9: When a reload finds no eligible center, `load_stb` stays 0, `sel_ctr` returns to 0 and the block goes back to waiting for an idle bus.
- R10: Engine events arriving while no frame is loaded have no effect. They give no done pulse, no load, and do not clear any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req_set | input | N_CTR | One-cycle pulses setting a center's pending request |
| ctr_ready | input | N_CTR | Per-center ready bit |
| ctr_tx_dir | input | N_CTR | Per-center transmit-direction bit |
| bus_idle | input | 1 | Bus is idle; a new pick may be loaded |
| ev_tx_ok | input | 1 | Engine: loaded frame sent |
| ev_arb_lost | input | 1 | Engine: arbitration lost |
| ev_error | input | 1 | Engine: error condition |
| load_stb | output | 1 | One-cycle strobe loading `sel_ctr` into the transmit buffer |
| sel_ctr | output | IDX_W | Loaded center number, 0 when none |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_ctr | output | IDX_W | Center whose frame was sent |

## Verification
The bench sweeps every combination of ready and direction bits over a six-center configuration. This exposes a picker that favours the highest number, ignores one of the qualifying bits, or lets the receive-only center through. Directed sequences cover three more cases: a higher center readied while the bus is busy (a design that latched its pick early would load the stale center), reloads after lost arbitration and errors (a design that blindly retried would keep the lower-priority frame), and a reload with nothing eligible. Separate checks confirm that a sent center is not reloaded until it is requested again, and that events arriving with no frame loaded leave the pending requests intact. A design that cleared the request on the wrong event, or acted on stray events, would load the wrong frame or raise a spurious done pulse.

// File: rtl/mbsel_pkg.sv
package mbsel_pkg;
  typedef enum logic [0:0] {
    ST_EMPTY = 1'b0,
    ST_HELD  = 1'b1
  } mbsel_state_e;
endpackage

// File: rtl/mbsel_pending_bank.sv
module mbsel_pending_bank #(
  parameter int N_CTR = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CTR-1:0] set_i,
  input  logic [N_CTR-1:0] clr_i,
  output logic [N_CTR-1:0] pend_o
);
  // one request flag per center; a set in the same cycle as a clear wins
  for (genvar g = 0; g < N_CTR; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst)           flag_q <= 1'b0;
      else if (set_i[g]) flag_q <= 1'b1;
      else if (clr_i[g]) flag_q <= 1'b0;
    end
    assign pend_o[g] = flag_q;
  end
endmodule

// File: rtl/mbsel_pick.sv
module mbsel_pick #(
  parameter int N_CTR = 15,
  parameter int IDX_W = $clog2(N_CTR + 1)
) (
  input  logic [N_CTR-1:0] elig_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] ctr_o
);
  logic [N_CTR-1:0] cand;

  // the top center is receive-only: drop it from the candidate set
  for (genvar g = 0; g < N_CTR; g++) begin : g_cand
    if (g == N_CTR - 1) begin : g_rx_only
      assign cand[g] = 1'b0;
    end else begin : g_tx
      assign cand[g] = elig_i[g];
    end
  end

  // lowest index wins: scan downward so the last hit kept is the lowest
  always_comb begin
    hit_o = 1'b0;
    ctr_o = '0;
    for (int i = N_CTR - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_o = 1'b1;
        ctr_o = IDX_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/mbsel_ctrl.sv
module mbsel_ctrl
  import mbsel_pkg::*;
#(
  parameter int N_CTR = 15,
  parameter int IDX_W = $clog2(N_CTR + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_idle,
  input  logic             ev_tx_ok,
  input  logic             ev_arb_lost,
  input  logic             ev_error,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] win_i,
  output logic [N_CTR-1:0] clr_o,
  output logic             load_stb,
  output logic [IDX_W-1:0] sel_ctr,
  output logic             done_pulse,
  output logic [IDX_W-1:0] done_ctr
);
  mbsel_state_e state_q;
  logic         held;
  logic         retry;

  assign held  = (state_q == ST_HELD);
  assign retry = ev_arb_lost | ev_error;

  // request clear for the center whose frame just went out
  for (genvar g = 0; g < N_CTR; g++) begin : g_clr
    assign clr_o[g] = held & ev_tx_ok & (sel_ctr == IDX_W'(g + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_EMPTY;
      load_stb   <= 1'b0;
      sel_ctr    <= '0;
      done_pulse <= 1'b0;
      done_ctr   <= '0;
    end else begin
      load_stb   <= 1'b0;
      done_pulse <= 1'b0;
      unique case (state_q)
        ST_EMPTY: begin
          if (bus_idle && hit_i) begin
            load_stb <= 1'b1;
            sel_ctr  <= win_i;
            state_q  <= ST_HELD;
          end
        end
        ST_HELD: begin
          if (ev_tx_ok) begin
            done_pulse <= 1'b1;
            done_ctr   <= sel_ctr;
            sel_ctr    <= '0;
            state_q    <= ST_EMPTY;
          end else if (retry) begin
            if (hit_i) begin
              load_stb <= 1'b1;
              sel_ctr  <= win_i;
            end else begin
              sel_ctr  <= '0;
              state_q  <= ST_EMPTY;
            end
          end
        end
        default: state_q <= ST_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/mbsel_tx_select.sv
module mbsel_tx_select #(
  parameter int N_CTR = 15,
  parameter int IDX_W = $clog2(N_CTR + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CTR-1:0] tx_req_set,
  input  logic [N_CTR-1:0] ctr_ready,
  input  logic [N_CTR-1:0] ctr_tx_dir,
  input  logic             bus_idle,
  input  logic             ev_tx_ok,
  input  logic             ev_arb_lost,
  input  logic             ev_error,
  output logic             load_stb,
  output logic [IDX_W-1:0] sel_ctr,
  output logic             done_pulse,
  output logic [IDX_W-1:0] done_ctr
);
  logic [N_CTR-1:0] pend;
  logic [N_CTR-1:0] clr;
  logic [N_CTR-1:0] elig;
  logic             hit;
  logic [IDX_W-1:0] win;

  mbsel_pending_bank #(.N_CTR(N_CTR)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (tx_req_set),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign elig = pend & ctr_ready & ctr_tx_dir;

  mbsel_pick #(.N_CTR(N_CTR), .IDX_W(IDX_W)) u_pick (
    .elig_i (elig),
    .hit_o  (hit),
    .ctr_o  (win)
  );

  mbsel_ctrl #(.N_CTR(N_CTR), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bus_idle    (bus_idle),
    .ev_tx_ok    (ev_tx_ok),
    .ev_arb_lost (ev_arb_lost),
    .ev_error    (ev_error),
    .hit_i       (hit),
    .win_i       (win),
    .clr_o       (clr),
    .load_stb    (load_stb),
    .sel_ctr     (sel_ctr),
    .done_pulse  (done_pulse),
    .done_ctr    (done_ctr)
  );
endmodule

// File: rtl/mbsel_tx_select_chk.sv
module mbsel_tx_select_chk #(
  parameter int N_CTR = 15,
  parameter int IDX_W = $clog2(N_CTR + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_CTR-1:0] elig,
  input logic             bus_idle,
  input logic             ev_tx_ok,
  input logic             ev_arb_lost,
  input logic             ev_error,
  input logic             load_stb,
  input logic [IDX_W-1:0] sel_ctr,
  input logic             done_pulse,
  input logic [IDX_W-1:0] done_ctr
);
  logic [N_CTR-1:0] elig_q;
  logic             below_hit;

  always_ff @(posedge clk) begin
    if (rst) elig_q <= '0;
    else     elig_q <= elig;
  end

  always_comb begin
    below_hit = 1'b0;
    for (int i = 0; i < N_CTR; i++) begin
      if ((i + 1 < int'(sel_ctr)) && elig_q[i]) below_hit = 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!load_stb && !done_pulse && sel_ctr == '0));

  p_lowest_wins_r3: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (sel_ctr != '0 && elig_q[sel_ctr - 1'b1] && !below_hit));

  p_rx_only_never_r4: assert property (@(posedge clk) disable iff (rst)
    sel_ctr != IDX_W'(N_CTR));

  p_load_cause_r5: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> $past(bus_idle || ev_arb_lost || ev_error));

  p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> ($past(ev_tx_ok) && !load_stb && sel_ctr == '0 && done_ctr != '0));

  p_no_load_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |=> !load_stb);
endmodule

bind mbsel_tx_select mbsel_tx_select_chk #(.N_CTR(N_CTR), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .elig        (elig),
  .bus_idle    (bus_idle),
  .ev_tx_ok    (ev_tx_ok),
  .ev_arb_lost (ev_arb_lost),
  .ev_error    (ev_error),
  .load_stb    (load_stb),
  .sel_ctr     (sel_ctr),
  .done_pulse  (done_pulse),
  .done_ctr    (done_ctr)
);

// File: tb/test_mbsel_tx_select.sv
module test_mbsel_tx_select;
  localparam int N  = 6;
  localparam int IW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  tx_req_set = '0;
  logic [N-1:0]  ctr_ready = '0;
  logic [N-1:0]  ctr_tx_dir = '0;
  logic          bus_idle = 1'b0;
  logic          ev_tx_ok = 1'b0;
  logic          ev_arb_lost = 1'b0;
  logic          ev_error = 1'b0;
  logic          load_stb;
  logic [IW-1:0] sel_ctr;
  logic          done_pulse;
  logic [IW-1:0] done_ctr;

  int n_chk = 0;
  int n_fail = 0;
  logic [N-1:0] pend_m = '0;

  mbsel_tx_select #(.N_CTR(N), .IDX_W(IW)) i_mbsel_tx_select (
    .clk(clk), .rst(rst), .tx_req_set(tx_req_set), .ctr_ready(ctr_ready),
    .ctr_tx_dir(ctr_tx_dir), .bus_idle(bus_idle), .ev_tx_ok(ev_tx_ok),
    .ev_arb_lost(ev_arb_lost), .ev_error(ev_error), .load_stb(load_stb),
    .sel_ctr(sel_ctr), .done_pulse(done_pulse), .done_ctr(done_ctr)
  );

  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] e);
    int w = 0;
    for (int i = N - 2; i >= 0; i--) if (e[i]) w = i + 1;
    return w;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int exp;
    repeat (3) step();
    chk(!load_stb && !done_pulse && sel_ctr == 0, "R1 reset outputs", int'(sel_ctr), 0);
    rst = 1'b0;
    ctr_ready = '1; ctr_tx_dir = '1; bus_idle = 1'b1;
    step();
    chk(!load_stb && sel_ctr == 0, "R1 first cycle", int'(load_stb), 0);
    step();
    chk(!load_stb, "R1 no pending after reset", int'(load_stb), 0);
    bus_idle = 1'b0;

    // raise every request
    tx_req_set = '1; step(); tx_req_set = '0; pend_m = '1;

    // R2 R3 R4: exhaustive ready x direction sweep
    for (int r = 0; r < (1 << N); r++) begin
      for (int d = 0; d < (1 << N); d++) begin
        ctr_ready = N'(r); ctr_tx_dir = N'(d); bus_idle = 1'b1;
        exp = lowest(pend_m & N'(r) & N'(d));
        step();
        chk(load_stb == (exp != 0), "R3 sweep strobe", int'(load_stb), int'(exp != 0));
        chk(int'(sel_ctr) == exp, "R3 R4 sweep pick", int'(sel_ctr), exp);
        bus_idle = 1'b0;
        if (exp != 0) begin
          ctr_ready = '0; ev_arb_lost = 1'b1;
          step();
          ev_arb_lost = 1'b0;
          chk(!load_stb && sel_ctr == 0, "R9 reload with none eligible", int'(sel_ctr), 0);
        end
      end
    end

    // R5: busy bus holds off load, later higher center takes over
    ctr_tx_dir = '1; ctr_ready = 6'b000100; bus_idle = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(!load_stb, "R5 no load while busy", int'(load_stb), 0);
    end
    ctr_ready = 6'b000110;
    step();
    bus_idle = 1'b1;
    step();
    bus_idle = 1'b0;
    chk(load_stb && sel_ctr == 2, "R5 fresh pick at idle", int'(sel_ctr), 2);

    // R6: arbitration lost reloads higher center
    ctr_ready = 6'b000111;
    step();
    chk(!load_stb && sel_ctr == 2, "R6 held between events", int'(sel_ctr), 2);
    ev_arb_lost = 1'b1; step(); ev_arb_lost = 1'b0;
    chk(load_stb && sel_ctr == 1, "R6 reload higher", int'(sel_ctr), 1);
    ev_arb_lost = 1'b1; step(); ev_arb_lost = 1'b0;
    chk(load_stb && sel_ctr == 1, "R6 reload same", int'(sel_ctr), 1);

    // R7: error reloads the current best
    ctr_ready = 6'b000100;
    ev_error = 1'b1; step(); ev_error = 1'b0;
    chk(load_stb && sel_ctr == 3, "R7 error reload", int'(sel_ctr), 3);

    // R8: success with a simultaneous arb-lost; success wins
    ev_tx_ok = 1'b1; ev_arb_lost = 1'b1; step(); ev_tx_ok = 1'b0; ev_arb_lost = 1'b0;
    pend_m[2] = 1'b0;
    chk(done_pulse && done_ctr == 3, "R8 done pulse center", int'(done_ctr), 3);
    chk(!load_stb && sel_ctr == 0, "R8 no load with done", int'(sel_ctr), 0);
    bus_idle = 1'b1;
    step();
    chk(!done_pulse, "R8 done one cycle", int'(done_pulse), 0);
    step();
    chk(!load_stb, "R2 R8 sent center not reloaded", int'(load_stb), 0);
    tx_req_set = 6'b000100; step(); tx_req_set = '0;
    chk(!load_stb, "R2 request visible next cycle", int'(load_stb), 0);
    step();
    chk(load_stb && sel_ctr == 3, "R2 re-requested center loads", int'(sel_ctr), 3);

    // R10: events while empty are ignored
    bus_idle = 1'b0; ctr_ready = '0; ev_arb_lost = 1'b1; step(); ev_arb_lost = 1'b0;
    chk(sel_ctr == 0, "R9 back to empty", int'(sel_ctr), 0);
    ctr_ready = 6'b000100;
    ev_tx_ok = 1'b1; step(); ev_tx_ok = 1'b0;
    chk(!done_pulse && !load_stb, "R10 tx_ok ignored when empty", int'(done_pulse), 0);
    ev_arb_lost = 1'b1; ev_error = 1'b1; step(); ev_arb_lost = 1'b0; ev_error = 1'b0;
    chk(!load_stb && sel_ctr == 0, "R10 retry ignored when empty", int'(load_stb), 0);
    bus_idle = 1'b1; step();
    chk(load_stb && sel_ctr == 3, "R10 request kept", int'(sel_ctr), 3);

    // R4: receive-only center alone
    bus_idle = 1'b0; ctr_ready = '0; ev_error = 1'b1; step(); ev_error = 1'b0;
    ctr_ready = 6'b100000; bus_idle = 1'b1;
    step();
    chk(!load_stb && sel_ctr == 0, "R4 top center never loaded", int'(sel_ctr), 0);
    step();
    chk(!load_stb, "R4 top center still idle", int'(load_stb), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule